// File: doc/BRIEF.md
# Multi-Channel TDM Serial Transmitter

This block is the transmit side of a time-division-multiplexed synchronous serial port. It drives up to three serial data lines, one per channel, and each channel can be enabled on its own. A bit strobe sets the bit timing. Every slot carries one word per channel, sent most significant bit first. A frame holds a single slot in normal mode, and in network mode it holds a configurable number of slots from 1 to 32. Frame-sync generation, clock generation and reception are handled elsewhere.

The CPU writes one data register per channel and a slot-control register, and it reads a status vector. All enabled channels share three status flags. The empty flag requests new data and the underrun flag reports a missed slot. The frame flag marks the first slot of a frame. When a channel misses a slot, its previous word is sent again. In network mode, writing the slot-control register silences the next slot on every line. That write also counts as servicing the port. Two interrupt requests follow the empty and underrun flags, each through its own enable.

Top module: `tdm_tx`

## Requirements
- R1: A slot starts on every `bit_en_i` strobe taken while the bit position is 0, and it lasts WORD_W strobes. During a slot, each enabled channel drives its word on `sdo_o[c]` MSB first. The line changes in the clock after each strobe. A channel whose `ch_en_i` bit is 0 holds its line low.
- R2: In normal mode (`net_mode_i`=0) every slot is the first slot of its frame. In network mode a frame holds `slots_i` slots; a value of 0 counts as 1.
- R3: The empty flag (`status_o[0]`) sets at every slot start. It clears in the cycle after a channel write that leaves every enabled channel holding new data.
- R4: `tx_irq_o` is high exactly when the empty flag and `tx_ie_i` are both 1.
- R5: The underrun flag (`status_o[1]`) sets at a slot start that is not silenced if some enabled channel holds no new data. That channel's previous word is sent again. A slot start uses up all new data.
- R6: The underrun flag clears only when two steps have happened in order. First a status read (`stat_rd_i`) is taken while the flag is 1. Then, in a later cycle, comes a write that completes the data of all enabled channels, or a slot-control write that is accepted. A new underrun overrides the clear and cancels the pending read. `err_irq_o` equals the underrun flag ANDed with `err_ie_i`.
- R7: A write is decoded by `wr_sel_i`: code c below 3 addresses channel c, and code 3 addresses slot control. In network mode a slot-control write clears the empty flag and silences the next slot start. In a silenced slot all lines are low, the empty flag sets, no underrun is flagged, and new data stays pending for the slot after it.
- R8: In normal mode a slot-control write is ignored. The empty flag keeps its value and the next slot sends data.
- R9: The frame flag (`status_o[2]`) is 1 from the start of a frame's first slot until the next slot start, and 0 in every other slot. In network mode, data written while the flag is 1 goes out in the second slot.
- R10: While reset is active, all lines, flags and interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle strobe per serial bit |
| net_mode_i | input | 1 | 1 = network mode, 0 = normal mode |
| slots_i | input | 6 | Slots per frame in network mode |
| ch_en_i | input | 3 | Per-channel enable |
| tx_ie_i | input | 1 | Empty interrupt enable |
| err_ie_i | input | 1 | Underrun interrupt enable |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0..2 channel, 3 slot control |
| wr_data_i | input | 8 | Write data |
| stat_rd_i | input | 1 | Status read strobe |
| sdo_o | output | 3 | Serial data, one line per channel |
| status_o | output | 3 | {frame, underrun, empty} |
| tx_irq_o | output | 1 | Empty interrupt request |
| err_irq_o | output | 1 | Underrun interrupt request |

## Verification
The assertions assume that mode, slot count, channel enables and interrupt enables change only while reset is held. With that rule the slot counter never runs past the frame length, and a silenced slot always follows a slot-control write made in network mode. The bench sets each configuration inside a reset pulse and changes only the bit strobe, the writes and the status reads while running. Writes and reads land at whatever point of a slot the polling loop reaches, so some of them coincide with slot starts.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int unsigned ST_TDE = 0;
  localparam int unsigned ST_TUE = 1;
  localparam int unsigned ST_TFS = 2;
  localparam int unsigned ST_W   = 3;
endpackage

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing #(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned MAX_SLOTS = 32,
  localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS + 1),
  localparam int unsigned CNT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int unsigned BIT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              net_mode_i,
  input  logic [SLOT_W-1:0] slots_i,
  output logic              start_o,
  output logic              shift_o,
  output logic              first_o
);
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  slot_q;
  logic [SLOT_W-1:0] eff_slots;
  logic [SLOT_W-1:0] slot_inc;
  logic              slot_end;

  always_comb begin
    if (!net_mode_i || slots_i == '0) eff_slots = SLOT_W'(1);
    else if (slots_i > SLOT_W'(MAX_SLOTS)) eff_slots = SLOT_W'(MAX_SLOTS);
    else eff_slots = slots_i;
  end

  assign slot_inc = SLOT_W'(slot_q) + SLOT_W'(1);
  assign slot_end = bit_en_i && (bit_q == BIT_W'(WORD_W - 1));
  assign start_o  = bit_en_i && (bit_q == '0);
  assign shift_o  = bit_en_i && (bit_q != '0);
  assign first_o  = (slot_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else if (bit_en_i) begin
      if (slot_end) begin
        bit_q  <= '0;
        slot_q <= (slot_inc >= eff_slots) ? '0 : CNT_W'(slot_inc);
      end else begin
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end

  assert_slot_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SLOT_W'(slot_q) < eff_slots);
endmodule

// File: rtl/tdm_tx_chan.sv
module tdm_tx_chan #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic              kill_i,
  input  logic              shift_i,
  input  logic              en_i,
  output logic              sdo_o
);
  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      shift_q <= '0;
    end else begin
      if (wr_i) data_q <= wdata_i;
      // old word is reloaded when not rewritten (retransmit on underrun)
      if (load_i) shift_q <= kill_i ? '0 : data_q;
      else if (shift_i) shift_q <= {shift_q[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo_o = en_i & shift_q[WORD_W-1];
endmodule

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              first_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] ch_wr_i,
  input  logic              slot_wr_i,
  input  logic              stat_rd_i,
  input  logic              tx_ie_i,
  input  logic              err_ie_i,
  output logic              kill_o,
  output logic              tde_o,
  output logic              tue_o,
  output logic              tfs_o,
  output logic              tx_irq_o,
  output logic              err_irq_o
);
  logic [NUM_CH-1:0] fresh_q, fresh_n;
  logic tde_q, tde_n, tue_q, tue_n, tfs_q, tfs_n;
  logic dis_q, dis_n, armed_q, armed_n;
  logic urun, full, service, live_start;

  always_comb begin
    live_start = start_i & ~dis_q;
    urun       = live_start & |(ch_en_i & ~fresh_q);
    fresh_n    = (live_start ? '0 : fresh_q) | ch_wr_i;
    full       = (|ch_wr_i) && ((fresh_n & ch_en_i) == ch_en_i);
    service    = full | slot_wr_i;

    tde_n = start_i ? 1'b1 : tde_q;
    if (service) tde_n = 1'b0;

    dis_n = start_i ? 1'b0 : dis_q;
    if (slot_wr_i) dis_n = 1'b1;

    tue_n   = tue_q;
    armed_n = armed_q | (stat_rd_i & tue_q);
    if (armed_q && service) begin
      tue_n   = 1'b0;
      armed_n = 1'b0;
    end
    if (urun) begin
      tue_n   = 1'b1;
      armed_n = 1'b0;
    end

    tfs_n = start_i ? first_i : tfs_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_q <= '0;
      tde_q   <= 1'b0;
      tue_q   <= 1'b0;
      tfs_q   <= 1'b0;
      dis_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      fresh_q <= fresh_n;
      tde_q   <= tde_n;
      tue_q   <= tue_n;
      tfs_q   <= tfs_n;
      dis_q   <= dis_n;
      armed_q <= armed_n;
    end
  end

  assign kill_o    = dis_q;
  assign tde_o     = tde_q;
  assign tue_o     = tue_q;
  assign tfs_o     = tfs_q;
  assign tx_irq_o  = tde_q & tx_ie_i;
  assign err_irq_o = tue_q & err_ie_i;

  assert_tde_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !(|ch_wr_i) && !slot_wr_i) |=> tde_q);

  assert_tue_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tue_q) |-> $past(start_i));

  assert_tue_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tue_q && !armed_q) |=> tue_q);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned MAX_SLOTS = 32,
  localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS + 1),
  localparam int unsigned SEL_W    = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              net_mode_i,
  input  logic [SLOT_W-1:0] slots_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              tx_ie_i,
  input  logic              err_ie_i,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              stat_rd_i,
  output logic [NUM_CH-1:0] sdo_o,
  output logic [ST_W-1:0]   status_o,
  output logic              tx_irq_o,
  output logic              err_irq_o
);
  localparam logic [SEL_W-1:0] SLOT_SEL = SEL_W'(NUM_CH);

  logic start, shift, first, kill, slot_wr;
  logic tde, tue, tfs;
  logic [NUM_CH-1:0] ch_wr;

  assign slot_wr = wr_i && (wr_sel_i == SLOT_SEL) && net_mode_i;

  tdm_tx_timing #(.WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS)) i_timing (
    .clk_i, .rst_ni, .bit_en_i, .net_mode_i, .slots_i,
    .start_o(start), .shift_o(shift), .first_o(first)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(c);
    assign ch_wr[c] = wr_i && (wr_sel_i == MY_SEL);
    tdm_tx_chan #(.WORD_W(WORD_W)) i_chan (
      .clk_i, .rst_ni,
      .wr_i(ch_wr[c]), .wdata_i(wr_data_i),
      .load_i(start), .kill_i(kill), .shift_i(shift),
      .en_i(ch_en_i[c]), .sdo_o(sdo_o[c])
    );
  end

  tdm_tx_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk_i, .rst_ni, .start_i(start), .first_i(first),
    .ch_en_i, .ch_wr_i(ch_wr), .slot_wr_i(slot_wr), .stat_rd_i,
    .tx_ie_i, .err_ie_i, .kill_o(kill),
    .tde_o(tde), .tue_o(tue), .tfs_o(tfs),
    .tx_irq_o, .err_irq_o
  );

  always_comb begin
    status_o         = '0;
    status_o[ST_TDE] = tde;
    status_o[ST_TUE] = tue;
    status_o[ST_TFS] = tfs;
  end

  assert_dis_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && kill) |=> (sdo_o == '0));
endmodule

// File: tb/test_tdm_tx.sv
module test_tdm_tx;
  localparam int NCH = 3;
  localparam int W   = 8;
  localparam int SLOT_SEL = 3;

  logic clk = 0, rst_n = 0, bit_en = 0, net = 0;
  logic [5:0] slots = 6'd1;
  logic [NCH-1:0] en = '1;
  logic tx_ie = 0, err_ie = 0, wr = 0, stat_rd = 0;
  logic [1:0] sel = '0;
  logic [W-1:0] wdata = '0;
  logic [NCH-1:0] sdo;
  logic [2:0] status;
  logic tx_irq, err_irq;

  int nchk = 0, nerr = 0, seed = 1;
  bit done = 0;

  always #10 clk = ~clk;

  tdm_tx i_tdm_tx (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .net_mode_i(net),
    .slots_i(slots), .ch_en_i(en), .tx_ie_i(tx_ie), .err_ie_i(err_ie),
    .wr_i(wr), .wr_sel_i(sel), .wr_data_i(wdata), .stat_rd_i(stat_rd),
    .sdo_o(sdo), .status_o(status), .tx_irq_o(tx_irq), .err_irq_o(err_irq)
  );

  always @(negedge clk) bit_en <= rst_n ? ~bit_en : 1'b0;

  // behavioural reference
  int m_bpos, m_slot, m_oidx, m_eff;
  bit [W-1:0] m_dreg[NCH], m_cur[NCH];
  bit m_fresh[NCH];
  bit m_tde, m_tue, m_tfs, m_armed, m_dis;
  bit m_urun, m_anywr, m_allnew, m_serv, m_newarm, m_slw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bpos = 0; m_slot = 0; m_oidx = 0;
      m_tde = 0; m_tue = 0; m_tfs = 0; m_armed = 0; m_dis = 0;
      for (int c = 0; c < NCH; c++) begin m_dreg[c] = 0; m_cur[c] = 0; m_fresh[c] = 0; end
    end else begin
      m_eff = (net && slots != 0) ? int'(slots) : 1;
      m_urun = 0;
      m_newarm = m_armed | (stat_rd & m_tue);
      m_slw = wr && sel == SLOT_SEL && net;
      if (bit_en && m_bpos == 0) begin
        if (m_dis) begin
          for (int c = 0; c < NCH; c++) m_cur[c] = 0;
        end else begin
          for (int c = 0; c < NCH; c++) begin
            if (en[c] && !m_fresh[c]) m_urun = 1;
            m_cur[c] = m_dreg[c];
            m_fresh[c] = 0;
          end
        end
        m_tde = 1; m_tfs = (m_slot == 0); m_dis = 0; m_oidx = 0;
      end else if (bit_en && m_oidx < W - 1) m_oidx++;
      if (bit_en) begin
        if (m_bpos == W - 1) begin
          m_bpos = 0;
          m_slot = (m_slot + 1 >= m_eff) ? 0 : m_slot + 1;
        end else m_bpos++;
      end
      m_anywr = 0;
      for (int c = 0; c < NCH; c++)
        if (wr && sel == c) begin m_dreg[c] = wdata; m_fresh[c] = 1; m_anywr = 1; end
      m_allnew = 1;
      for (int c = 0; c < NCH; c++) if (en[c] && !m_fresh[c]) m_allnew = 0;
      m_serv = (m_anywr && m_allnew) || m_slw;
      if (m_slw) m_dis = 1;
      if (m_serv) m_tde = 0;
      if (m_armed && m_serv) begin m_tue = 0; m_newarm = 0; end
      if (m_urun) begin m_tue = 1; m_newarm = 0; end
      m_armed = m_newarm;
    end
  end

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NCH-1:0] es;
      for (int c = 0; c < NCH; c++) es[c] = en[c] & m_cur[c][W-1-m_oidx];
      check("R1 R5 R7 R8 sdo", int'(sdo), int'(es));
      check("R3 R7 empty", int'(status[0]), int'(m_tde));
      check("R5 R6 underrun", int'(status[1]), int'(m_tue));
      check("R2 R9 frame", int'(status[2]), int'(m_tfs));
      check("R4 tx_irq", int'(tx_irq), int'(m_tde & tx_ie));
      check("R6 err_irq", int'(err_irq), int'(m_tue & err_ie));
    end
  end

  task automatic do_reset(bit n, int s, logic [NCH-1:0] e, bit ti, bit ei);
    @(negedge clk); rst_n = 0; net = n; slots = 6'(s); en = e; tx_ie = ti; err_ie = ei;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_reg(int s, logic [W-1:0] d);
    @(negedge clk); wr = 1; sel = 2'(s); wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic stat_read();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic service(logic [NCH-1:0] mask);
    do @(negedge clk); while (!status[0]);
    for (int c = 0; c < NCH; c++)
      if (mask[c]) begin
        seed = (seed * 37 + 11) % 251;
        wr_reg(c, 8'(seed) | 8'h81);
      end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (2) @(negedge clk);
    check("R10 reset sdo", int'(sdo), 0);
    check("R10 reset status", int'(status), 0);
    check("R10 reset irq", int'({tx_irq, err_irq}), 0);

    // normal mode, all channels
    do_reset(0, 1, 3'b111, 1, 1);
    repeat (2) service(3'b111);
    stat_read();
    service(3'b111);
    @(negedge clk);
    check("R6 underrun cleared", int'(status[1]), 0);
    repeat (3) service(3'b111);

    // underrun with stale channel 2
    service(3'b011);
    repeat (20) @(negedge clk);
    check("R5 underrun set", int'(status[1]), 1);
    check("R6 err irq", int'(err_irq), 1);
    service(3'b111);
    @(negedge clk);
    check("R6 no clear without read", int'(status[1]), 1);
    stat_read();
    service(3'b111);
    @(negedge clk);
    check("R6 cleared after read", int'(status[1]), 0);

    // slot write ignored in normal mode
    do @(negedge clk); while (!status[0]);
    wr_reg(SLOT_SEL, 8'h00);
    check("R8 empty kept", int'(status[0]), 1);
    repeat (3) service(3'b111);

    // network mode, 4 slots
    do_reset(1, 4, 3'b101, 1, 0);
    for (int i = 0; i < 12; i++) begin
      service(3'b101);
      if (i % 3 == 1) begin
        wr_reg(SLOT_SEL, 8'h00);
        check("R7 empty cleared by slot write", int'(status[0]), 0);
      end
    end
    stat_read();
    service(3'b101);
    while (status[2]) @(negedge clk);
    while (!status[2]) @(negedge clk);
    cnt = 0;
    while (status[2]) begin @(negedge clk); cnt++; end
    check("R9 frame flag one slot", cnt, 2 * W);
    while (!status[2]) begin @(negedge clk); cnt++; end
    check("R2 frame length", cnt, 4 * 2 * W);

    // network mode, 32 slots
    do_reset(1, 32, 3'b111, 1, 1);
    repeat (40) service(3'b111);
    stat_read();
    service(3'b111);
    repeat (40) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule